// File: doc/BRIEF.md
# Bridge I/O Forwarding Decoder

This block sits beside the address phase of a bridge that joins a primary bus to a secondary bus. For each transaction offered to it, it decides whether the bridge should claim the cycle and carry it across. Downstream means from the primary side to the secondary side. Upstream means the other way. Each offered transaction comes with its address, whether it is an I/O or a memory cycle, and the side it was seen on. One clock later the block returns a registered decision strobe and two forwarding flags.

The decision rests on a programmable I/O window with 4KB granularity and two control bits. The first is an ISA alias mode. Inside the window and below 64KB, it removes from the window the upper three quarters of every 1KB block, and it sends secondary-side cycles in those holes upstream instead. The second is a legacy display override. It forwards the classic display memory and I/O ranges downstream whatever the window holds. Software sets the window and the control bits through a small synchronous write port.

Top module: `io_fwd_decoder`

## Requirements
- R1: After synchronous reset (`rst` high), `dec_valid`, `fwd_down` and `fwd_up` are 0. The window is disabled: the base page resets to all ones and the limit page to zero. Both control bits are clear, so no primary-side cycle is forwarded.
- R2: A write with `cfg_we` high takes effect at the clock edge. `cfg_sel` = 0 loads the window base page from `cfg_wdata[19:0]`. `cfg_sel` = 1 loads the limit page from `cfg_wdata[19:0]`. `cfg_sel` = 2 loads the control bits: `cfg_wdata[0]` is ISA alias mode and `cfg_wdata[1]` is display override. `cfg_sel` = 3 changes nothing.
- R3: The window is inclusive. It runs from {base,12'h000} to {limit,12'hFFF}. With ISA mode clear, any primary-side I/O address inside it gives `fwd_down` = 1, and any address outside it gives 0.
- R4: When the limit page is below the base page, no I/O address is inside the window.
- R5: With ISA mode set, a primary-side I/O address inside the window, below 0x10000, with address bits [9:8] nonzero is not forwarded downstream. With bits [9:8] zero it is still forwarded.
- R6: ISA mode has no effect on window addresses at or above 0x10000. They are forwarded downstream as usual.
- R7: A secondary-side I/O address gives `fwd_up` = 1 when it is outside the window, or when it lies in an ISA hole as defined in R5. A secondary-side address inside the window and not in a hole gives 0.
- R8: With display override set, primary-side memory addresses 0x000A0000 to 0x000BFFFF are forwarded downstream. Other memory addresses are never forwarded. With the override clear, no memory address is forwarded.
- R9: With display override set, primary-side I/O addresses whose low ten bits lie in 0x3B0–0x3BB or 0x3C0–0x3DF are forwarded downstream whatever the window holds. Address bits above bit 9 are ignored for this match.
- R10: A secondary-side I/O address that matches a display range while the override is set is not forwarded upstream.
- R11: `dec_valid` is high exactly in the cycle after each cycle with `req_valid` high, and the flags carry that request's decision. Both flags are 0 whenever `dec_valid` is 0. Requests may arrive on back-to-back cycles.
- R12: A primary-side request never raises `fwd_up`, and a secondary-side request never raises `fwd_down`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Register select: 0 base, 1 limit, 2 control, 3 none |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | A transaction is offered this cycle |
| req_addr | input | 32 | Transaction address |
| req_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| req_from_sec | input | 1 | 1 = seen on the secondary side, 0 = primary side |
| dec_valid | output | 1 | Decision strobe, one cycle after `req_valid` |
| fwd_down | output | 1 | Claim and forward primary to secondary |
| fwd_up | output | 1 | Claim and forward secondary to primary |

## Verification
The window is probed at its first and last byte and one byte beyond each edge. This separates an inclusive compare from an exclusive one and shows whether the 4KB granularity is applied. Addresses with bits [9:8] equal to zero and nonzero are offered from both sides with ISA mode on and off. The same hole offsets are repeated above 64KB, which tells the hole logic apart from the window logic and the 64KB bound from its absence. Display ranges are hit at their ends, just outside them, and through a high-bit alias, first with the window disabled so that only the override can forward. Back-to-back requests check that every decision lands on its own strobe.

// File: rtl/iofd_pkg.sv
package iofd_pkg;

  localparam int ADDR_W  = 32;
  localparam int GRAN_W  = 12;               // 4KB window granularity
  localparam int PAGE_W  = ADDR_W - GRAN_W;
  localparam int ISA_TOP = 16;               // ISA holes only below 64KB
  localparam int CFG_W   = 32;

  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_LIMIT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic vga_en;   // bit 1
    logic isa_en;   // bit 0
  } ctrl_t;

  // Page-number compare equals the byte compare with base low bits 0 and
  // limit low bits all ones.
  function automatic logic page_in_window(input logic [PAGE_W-1:0] pg,
                                          input logic [PAGE_W-1:0] base,
                                          input logic [PAGE_W-1:0] limit);
    return (pg >= base) && (pg <= limit);
  endfunction

  function automatic logic isa_alias_hole(input logic [ADDR_W-1:0] a);
    return (a[ADDR_W-1:ISA_TOP] == '0) && (a[9:8] != 2'b00);
  endfunction

  function automatic logic vga_mem_range(input logic [ADDR_W-1:0] a);
    return (a >= ADDR_W'(32'h000A_0000)) && (a <= ADDR_W'(32'h000B_FFFF));
  endfunction

  function automatic logic vga_io_range(input logic [ADDR_W-1:0] a);
    logic [9:0] lo;
    lo = a[9:0];
    return ((lo >= 10'h3B0) && (lo <= 10'h3BB)) ||
           ((lo >= 10'h3C0) && (lo <= 10'h3DF));
  endfunction

endpackage

// File: rtl/iofd_cfg_regs.sv
module iofd_cfg_regs
  import iofd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [PAGE_W-1:0] base_pg,
  output logic [PAGE_W-1:0] limit_pg,
  output ctrl_t             ctrl
);

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(cfg_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_pg  <= '1;
      limit_pg <= '0;
      ctrl     <= '0;
    end else if (cfg_we) begin
      case (sel)
        SEL_BASE:  base_pg  <= cfg_wdata[PAGE_W-1:0];
        SEL_LIMIT: limit_pg <= cfg_wdata[PAGE_W-1:0];
        SEL_CTRL:  ctrl     <= ctrl_t'(cfg_wdata[1:0]);
        default:   ;
      endcase
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(base_pg) && $stable(limit_pg) && $stable(ctrl)); // R2

  AST_CFG_SEL_NONE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == 2'd3) |=> $stable(base_pg) && $stable(limit_pg) && $stable(ctrl)); // R2

endmodule

// File: rtl/iofd_window_match.sv
module iofd_window_match
  import iofd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_io,
  input  logic [PAGE_W-1:0] base_pg,
  input  logic [PAGE_W-1:0] limit_pg,
  input  logic              isa_en,
  output logic              win_en,
  output logic              in_win,
  output logic              isa_hole
);

  assign win_en   = (limit_pg >= base_pg);
  assign in_win   = is_io && win_en &&
                    page_in_window(addr[ADDR_W-1:GRAN_W], base_pg, limit_pg);
  assign isa_hole = isa_en && in_win && isa_alias_hole(addr);

endmodule

// File: rtl/iofd_legacy_match.sv
module iofd_legacy_match
  import iofd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_io,
  input  logic              vga_en,
  output logic              vga_hit
);

  logic mem_hit;
  logic io_hit;

  assign mem_hit = !is_io && vga_mem_range(addr);
  assign io_hit  =  is_io && vga_io_range(addr);
  assign vga_hit = vga_en && (mem_hit || io_hit);

endmodule

// File: rtl/io_fwd_decoder.sv
module io_fwd_decoder
  import iofd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_io,
  input  logic              req_from_sec,
  output logic              dec_valid,
  output logic              fwd_down,
  output logic              fwd_up
);

  logic [PAGE_W-1:0] base_pg;
  logic [PAGE_W-1:0] limit_pg;
  ctrl_t             ctrl;
  logic              win_en;
  logic              in_win;
  logic              isa_hole;
  logic              vga_hit;
  logic              fwd_down_d;
  logic              fwd_up_d;
  logic              dir_q;

  iofd_cfg_regs u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .base_pg   (base_pg),
    .limit_pg  (limit_pg),
    .ctrl      (ctrl)
  );

  iofd_window_match u_win (
    .addr     (req_addr),
    .is_io    (req_is_io),
    .base_pg  (base_pg),
    .limit_pg (limit_pg),
    .isa_en   (ctrl.isa_en),
    .win_en   (win_en),
    .in_win   (in_win),
    .isa_hole (isa_hole)
  );

  iofd_legacy_match u_vga (
    .addr    (req_addr),
    .is_io   (req_is_io),
    .vga_en  (ctrl.vga_en),
    .vga_hit (vga_hit)
  );

  // Downstream: display override wins; otherwise window minus ISA holes.
  assign fwd_down_d = !req_from_sec && (vga_hit || (in_win && !isa_hole));
  // Upstream: I/O not owned by the secondary side's window, or in a hole.
  assign fwd_up_d   = req_from_sec && req_is_io && !vga_hit &&
                      (!in_win || isa_hole);

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      fwd_down  <= 1'b0;
      fwd_up    <= 1'b0;
      dir_q     <= 1'b0;
    end else begin
      dec_valid <= req_valid;
      fwd_down  <= req_valid && fwd_down_d;
      fwd_up    <= req_valid && fwd_up_d;
      dir_q     <= req_from_sec;
    end
  end

  AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> dec_valid); // R11

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !dec_valid && !fwd_down && !fwd_up); // R11

  AST_ONE_WAY: assert property (@(posedge clk) disable iff (rst)
    fwd_down |-> !fwd_up); // R12

  AST_DIR_MATCH: assert property (@(posedge clk) disable iff (rst)
    (fwd_up |-> dir_q) and (fwd_down |-> !dir_q)); // R12

  AST_HOLE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_from_sec && isa_hole && !vga_hit) |=> !fwd_down); // R5

  AST_MEM_ONLY_VGA: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_is_io && !vga_hit) |=> !fwd_down && !fwd_up); // R8

  AST_VGA_NOT_UP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && vga_hit) |=> !fwd_up); // R10

  AST_NO_WIN_NO_CLAIM: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !win_en && !vga_hit && !req_from_sec) |=> !fwd_down); // R4

endmodule

// File: tb/sim_io_fwd_decoder.sv
module sim_io_fwd_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_is_io = 1'b0;
  logic        req_from_sec = 1'b0;
  logic        dec_valid;
  logic        fwd_down;
  logic        fwd_up;

  int checks = 0;
  int errors = 0;

  // bench copy of programmed state
  logic [19:0] m_base  = 20'hFFFFF;
  logic [19:0] m_limit = 20'h00000;
  logic        m_isa   = 1'b0;
  logic        m_vga   = 1'b0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;   // 50 MHz

  io_fwd_decoder u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_io(req_is_io), .req_from_sec(req_from_sec),
    .dec_valid(dec_valid), .fwd_down(fwd_down), .fwd_up(fwd_up)
  );

  // Reference model: byte-address window, bit-slice checks written afresh.
  function automatic logic [1:0] model(input logic [31:0] a, input logic io,
                                       input logic sec);
    logic [31:0] lo, hi;
    logic win, hole, disp, dn, up;
    lo   = {m_base, 12'h000};
    hi   = {m_limit, 12'hFFF};
    win  = io && (m_limit >= m_base) && (a >= lo) && (a <= hi);
    hole = m_isa && win && (a < 32'h10000) && (a[9] | a[8]);
    if (io)
      disp = m_vga && ((a[9:0] inside {[10'h3B0:10'h3BB]}) ||
                       (a[9:0] inside {[10'h3C0:10'h3DF]}));
    else
      disp = m_vga && (a >= 32'hA0000) && (a < 32'hC0000);
    dn = 1'b0; up = 1'b0;
    if (!sec) dn = disp | (win & ~hole);
    else if (io && !disp) up = ~win | hole;
    return {dn, up};
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    case (sel)
      2'd0: m_base  = d[19:0];
      2'd1: m_limit = d[19:0];
      2'd2: begin m_isa = d[0]; m_vga = d[1]; end
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // driver: offers one request for one cycle and pushes the expectation
  task automatic req(input logic [31:0] a, input logic io, input logic sec,
                     input string tag);
    req_valid = 1'b1; req_addr = a; req_is_io = io; req_from_sec = sec;
    exp_q.push_back(model(a, io, sec));
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: compares each strobe against the oldest expectation
  always @(negedge clk) begin
    if (!rst && dec_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected strobe: got down=%0b up=%0b expected none",
                 fwd_down, fwd_up);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({fwd_down, fwd_up} !== e) begin
          errors++;
          $display("FAIL %s: got down=%0b up=%0b expected down=%0b up=%0b",
                   t, fwd_down, fwd_up, e[1], e[0]);
        end
      end
    end else if (!rst && (fwd_down || fwd_up)) begin
      checks++; errors++;
      $display("FAIL R11 flag without strobe: got down=%0b up=%0b expected 0 0",
               fwd_down, fwd_up);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (dec_valid !== 1'b0 || fwd_down !== 1'b0 || fwd_up !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: got %0b%0b%0b expected 000",
               dec_valid, fwd_down, fwd_up);
    end
    // R1: reset config forwards nothing from primary
    req(32'h0000_1000, 1'b1, 1'b0, "R1 io after reset");
    req(32'h000A_0000, 1'b0, 1'b0, "R1 vga mem after reset");
    req(32'h0000_03C0, 1'b1, 1'b0, "R1 vga io after reset");

    // R2/R3: window 0x1000..0x2FFF, ISA off
    wr(2'd0, 32'h0000_0001);
    wr(2'd1, 32'h0000_0002);
    wr(2'd2, 32'h0);
    req(32'h0000_1000, 1'b1, 1'b0, "R3 window first byte");
    req(32'h0000_2FFF, 1'b1, 1'b0, "R3 window last byte");
    req(32'h0000_0FFF, 1'b1, 1'b0, "R3 below window");
    req(32'h0000_3000, 1'b1, 1'b0, "R3 above window");
    req(32'h0000_1300, 1'b1, 1'b0, "R3 hole offset isa off");
    req(32'h0000_1000, 1'b0, 1'b0, "R8 memory in io window");
    req(32'h0000_0FFF, 1'b1, 1'b1, "R7 sec outside window");
    req(32'h0000_1500, 1'b1, 1'b1, "R7 sec inside window isa off");
    req(32'h0000_1000, 1'b1, 1'b1, "R12 sec never down");
    req(32'h0000_0FFF, 1'b1, 1'b0, "R12 pri never up");

    // R2: select 3 changes nothing
    wr(2'd3, 32'hFFFF_FFFF);
    req(32'h0000_1100, 1'b1, 1'b0, "R2 sel3 no effect isa");
    req(32'h000A_0000, 1'b0, 1'b0, "R2 sel3 no effect vga");
    req(32'h0000_2FFF, 1'b1, 1'b0, "R2 sel3 no effect limit");

    // R5/R7: ISA on
    wr(2'd2, 32'h1);
    req(32'h0000_1100, 1'b1, 1'b0, "R5 hole blocked");
    req(32'h0000_13FF, 1'b1, 1'b0, "R5 hole top blocked");
    req(32'h0000_1400, 1'b1, 1'b0, "R5 low quarter forwarded");
    req(32'h0000_10FF, 1'b1, 1'b0, "R5 low quarter end forwarded");
    req(32'h0000_1100, 1'b1, 1'b1, "R7 sec hole goes up");
    req(32'h0000_1400, 1'b1, 1'b1, "R7 sec non-hole stays");
    req(32'h0000_0200, 1'b1, 1'b1, "R7 sec outside window isa");

    // R6: window at 64KB, ISA on
    wr(2'd0, 32'h0000_0010);
    wr(2'd1, 32'h0000_0010);
    req(32'h0001_0100, 1'b1, 1'b0, "R6 above 64KB forwarded");
    req(32'h0001_0300, 1'b1, 1'b0, "R6 above 64KB forwarded 2");
    req(32'h0001_0100, 1'b1, 1'b1, "R6 above 64KB no up");

    // R4: inverted window
    wr(2'd0, 32'h0000_0005);
    wr(2'd1, 32'h0000_0004);
    wr(2'd2, 32'h0);
    req(32'h0000_5000, 1'b1, 1'b0, "R4 disabled window");
    req(32'h0000_4FFF, 1'b1, 1'b0, "R4 disabled window 2");
    req(32'h0000_5000, 1'b1, 1'b1, "R4 sec up when disabled");

    // R8/R9/R10: display override, window disabled
    wr(2'd2, 32'h2);
    req(32'h000A_0000, 1'b0, 1'b0, "R8 vga mem low end");
    req(32'h000B_FFFF, 1'b0, 1'b0, "R8 vga mem high end");
    req(32'h0009_FFFF, 1'b0, 1'b0, "R8 below vga mem");
    req(32'h000C_0000, 1'b0, 1'b0, "R8 above vga mem");
    req(32'h000A_0000, 1'b0, 1'b1, "R8 sec vga mem");
    req(32'h0000_03B0, 1'b1, 1'b0, "R9 io 3B0");
    req(32'h0000_03BB, 1'b1, 1'b0, "R9 io 3BB");
    req(32'h0000_03BC, 1'b1, 1'b0, "R9 io 3BC gap");
    req(32'h0000_03C0, 1'b1, 1'b0, "R9 io 3C0");
    req(32'h0001_33DF, 1'b1, 1'b0, "R9 io alias 3DF");
    req(32'h0000_03E0, 1'b1, 1'b0, "R9 io 3E0");
    req(32'h0000_03C5, 1'b1, 1'b1, "R10 sec vga io not up");
    req(32'h0000_03E0, 1'b1, 1'b1, "R10 sec non-vga up");
    wr(2'd2, 32'h0);
    req(32'h0000_03C5, 1'b1, 1'b1, "R10 override off up");
    req(32'h000A_0000, 1'b0, 1'b0, "R8 override off mem");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11 missing strobes: got %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule